// File: doc/BRIEF.md
# Weighted Modulo 2^n+1 Two-Operand Adder

This block adds two operands held in the normal weighted form of a modulo 2^n+1 channel. Each operand is n+1 bits wide and lies in the range 0 to 2^n. The result is the (n+1)-bit weighted residue of their sum. The block is purely combinational. It is meant to sit in the 2^n+1 lane of a residue-number datapath, where a result that needs only one carry network keeps that lane from being slower than its 2^n-1 and 2^n neighbours.

The adder has two parts. A front-end row of carry-save cells folds the two low n-bit fields and a small correction constant into a pair of n-bit vectors. The sum of that pair is congruent to the true sum minus one. The correction constant is chosen from the two top bits. The pair then goes to an n-bit adder with an inverted end-around carry, built on a parallel-prefix carry tree. That adder returns the low n bits of the residue. A detector built from the tree's all-bit group propagate and group generate terms sets the result's top bit, and this detector sits off the carry path.

The width n is the parameter `W`.

Top module: `modp1_adder`

## Requirements
- R1: For every pair of operands A, B in 0..2^W, `sum_o` equals (A + B) mod (2^W + 1), taken as an unsigned integer. This holds with no clock: the output follows the inputs combinationally.
- R2: `sum_o` never exceeds 2^W. When `sum_o[W]` is 1, bits W-1..0 of `sum_o` are all 0.
- R3: `sum_o[W]` is 1 exactly when A + B equals 2^W. Examples: 2^(W-1) + 2^(W-1), and (2^W - 1) + 1.
- R4: When exactly one operand is 2^W (bit W set, lower bits 0), the result is (other - 1) mod (2^W + 1). With the other operand 0 the result is 2^W, and with the other operand 1 the result is 0.
- R5: When both operands are 2^W, the result is 2^W - 1.
- R6: When A + B is 2^W + 1 or more, the result is A + B - 2^W - 1. For example, (2^W - 1) + 2 gives 0.
- R7: R1 holds at the smallest width W = 2, where the front end has no constant-one cells, and also at the wider settings W = 5 and W = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W+1 | First weighted operand, 0..2^W; bit W set only for the value 2^W |
| b_i | input | W+1 | Second weighted operand, same encoding as a_i |
| sum_o | output | W+1 | Weighted residue (a_i + b_i) mod (2^W + 1), 0..2^W |

## Verification
At the default width, every legal operand pair is applied. This separates the three outcomes of the inverted end-around carry: a carry out of the n-bit pair, no carry, and the all-propagate case that must yield 2^W. Directed pairs with one or both operands at 2^W exercise the three correction constants, which a wrong NAND or XNOR term in the front end would shift by one. Exhaustive runs at W = 2 and W = 5 and a seeded random run at W = 16, biased toward the value 2^W, show that the generate structure is correct at widths where the front end has no upper cells and where the prefix tree is deeper.

// File: rtl/modp1_pkg.sv
package modp1_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // hi spans the more significant bits
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  function automatic int prefix_levels(int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/modp1_csa_map.sv
// Folds low fields plus correction into two n-bit vectors whose sum is A+B-1 mod 2^n+1
module modp1_csa_map #(
  parameter int W = 8
) (
  input  logic [W:0]   a_i,
  input  logic [W:0]   b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);

  logic [W-1:0] s_q;
  logic [W-1:0] cy_q;
  logic         top_a;
  logic         top_b;

  assign top_a = a_i[W];
  assign top_b = b_i[W];

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      // correction bit 0: 1 when top bits agree
      logic k;
      assign k       = ~(top_a ^ top_b);
      assign s_q[i]  = a_i[i] ^ b_i[i] ^ k;
      assign cy_q[i] = (a_i[i] & b_i[i]) | (k & (a_i[i] ^ b_i[i]));
    end else if (i == 1) begin : g_b1
      // correction bit 1: 0 only when both operands are 2^n
      logic k;
      assign k       = ~(top_a & top_b);
      assign s_q[i]  = a_i[i] ^ b_i[i] ^ k;
      assign cy_q[i] = (a_i[i] & b_i[i]) | (k & (a_i[i] ^ b_i[i]));
    end else begin : g_one
      // constant-one full adder
      assign s_q[i]  = ~(a_i[i] ^ b_i[i]);
      assign cy_q[i] = a_i[i] | b_i[i];
    end
  end

  assign x_o = s_q;
  // carry of weight 2^n wraps inverted into bit 0
  assign y_o = {cy_q[W-2:0], ~cy_q[W-1]};

endmodule

// File: rtl/modp1_prefix_tree.sv
module modp1_prefix_tree
  import modp1_pkg::*;
#(
  parameter int W = 8
) (
  input  gp_t [W-1:0] gp_i,
  output gp_t [W-1:0] grp_o
);

  localparam int L = prefix_levels(W);

  gp_t [W-1:0] lvl [L+1];

  assign lvl[0] = gp_i;

  for (genvar lv = 1; lv <= L; lv++) begin : g_lvl
    localparam int D = 1 << (lv - 1);
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign lvl[lv][i] = gp_merge(lvl[lv-1][i], lvl[lv-1][i-D]);
      end else begin : g_pass
        assign lvl[lv][i] = lvl[lv-1][i];
      end
    end
  end

  assign grp_o = lvl[L];

endmodule

// File: rtl/modp1_iac_core.sv
// Inverted end-around-carry adder; returns weighted residue of X+Y+1
module modp1_iac_core
  import modp1_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W:0]   sum_o
);

  gp_t  [W-1:0] bit_gp;
  gp_t  [W-1:0] grp;
  logic [W-1:0] half_q;
  logic [W-1:0] cin_q;
  logic         g_all;
  logic         top_q;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      bit_gp[i].g = x_i[i] & y_i[i];
      bit_gp[i].p = x_i[i] ^ y_i[i];
    end
  end

  assign half_q = x_i ^ y_i;

  modp1_prefix_tree #(.W(W)) u_tree (
    .gp_i  (bit_gp),
    .grp_o (grp)
  );

  assign g_all = grp[W-1].g;

  // carry-in is the inverted carry-out, folded in after the tree
  always_comb begin
    cin_q[0] = ~g_all;
    for (int i = 1; i < W; i++) begin
      cin_q[i] = grp[i-1].g | (grp[i-1].p & ~g_all);
    end
  end

  // all-propagate, no-generate: operands are bitwise complements
  assign top_q = grp[W-1].p & ~g_all;

  assign sum_o = {top_q, half_q ^ cin_q};

endmodule

// File: rtl/modp1_adder.sv
module modp1_adder #(
  parameter int W = 8
) (
  input  logic [W:0] a_i,
  input  logic [W:0] b_i,
  output logic [W:0] sum_o
);

  logic [W-1:0] map_x;
  logic [W-1:0] map_y;

  modp1_csa_map #(.W(W)) u_map (
    .a_i (a_i),
    .b_i (b_i),
    .x_o (map_x),
    .y_o (map_y)
  );

  modp1_iac_core #(.W(W)) u_core (
    .x_i   (map_x),
    .y_i   (map_y),
    .sum_o (sum_o)
  );

endmodule

// File: rtl/modp1_adder_chk.sv
module modp1_adder_chk #(
  parameter int W = 8
) (
  input logic [W:0]   a_i,
  input logic [W:0]   b_i,
  input logic [W:0]   sum_o,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i
);

  localparam logic [W+1:0] TWO_N = {2'b01, {W{1'b0}}};
  localparam logic [W+1:0] MOD   = TWO_N + (W+2)'(1);

  logic         in_rng;
  logic [W+1:0] tot;
  logic [W+1:0] ref_v;
  logic [W+1:0] map_v;

  always_comb begin
    in_rng = (~a_i[W] | ~|a_i[W-1:0]) & (~b_i[W] | ~|b_i[W-1:0]);
    tot    = {1'b0, a_i} + {1'b0, b_i};
    ref_v  = tot % MOD;
    map_v  = ({2'b00, x_i} + {2'b00, y_i} + (W+2)'(1)) % MOD;
    if (in_rng) begin
      p_residue_r1: assert ({1'b0, sum_o} == ref_v)
        else $error("residue mismatch");
      p_front_end_r1: assert (map_v == ref_v)
        else $error("front-end pair not congruent to A+B-1");
      p_no_overflow_r2: assert ({1'b0, sum_o} <= TWO_N)
        else $error("result above 2^n");
      p_top_clears_low_r2: assert (!sum_o[W] || (sum_o[W-1:0] == '0))
        else $error("top bit with nonzero low bits");
      p_top_exact_r3: assert (sum_o[W] == (tot == TWO_N))
        else $error("top bit disagrees with A+B==2^n");
    end
  end

endmodule

bind modp1_adder modp1_adder_chk #(.W(W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sum_o (sum_o),
  .x_i   (map_x),
  .y_i   (map_y)
);

// File: tb/modp1_adder_test.sv
`timescale 1ns/1ps
module modp1_adder_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [2:0]  a2 = '0, b2 = '0;
  logic [2:0]  s2;
  logic [5:0]  a5 = '0, b5 = '0;
  logic [5:0]  s5;
  logic [8:0]  a8 = '0, b8 = '0;
  logic [8:0]  s8;
  logic [16:0] a16 = '0, b16 = '0;
  logic [16:0] s16;

  modp1_adder #(.W(8))  uut     (.a_i(a8),  .b_i(b8),  .sum_o(s8));
  modp1_adder #(.W(2))  uut_w2  (.a_i(a2),  .b_i(b2),  .sum_o(s2));
  modp1_adder #(.W(5))  uut_w5  (.a_i(a5),  .b_i(b5),  .sum_o(s5));
  modp1_adder #(.W(16)) uut_w16 (.a_i(a16), .b_i(b16), .sum_o(s16));

  function automatic longint ref_res(int w, longint a, longint b);
    return (a + b) % ((64'sd1 << w) + 1);
  endfunction

  task automatic check(string tag, int w, longint a, longint b, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s W=%0d a=%0d b=%0d: got %0d expected %0d", tag, w, a, b, got, exp);
    end
  endtask

  task automatic apply(int w, longint a, longint b, output longint got);
    @(negedge clk);
    case (w)
      2:       begin a2  = 3'(a);  b2  = 3'(b);  end
      5:       begin a5  = 6'(a);  b5  = 6'(b);  end
      16:      begin a16 = 17'(a); b16 = 17'(b); end
      default: begin a8  = 9'(a);  b8  = 9'(b);  end
    endcase
    #1;
    case (w)
      2:       got = longint'(s2);
      5:       got = longint'(s5);
      16:      got = longint'(s16);
      default: got = longint'(s8);
    endcase
  endtask

  task automatic directed(string tag, longint a, longint b, longint exp);
    longint got;
    apply(8, a, b, got);
    check(tag, 8, a, b, got, exp);
  endtask

  task automatic sweep(int w, string tag);
    longint got;
    longint top = 64'sd1 << w;
    for (longint a = 0; a <= top; a++) begin
      for (longint b = 0; b <= top; b++) begin
        apply(w, a, b, got);
        check(tag, w, a, b, got, ref_res(w, a, b));
        if (w == 8) begin
          check("R2", w, a, b, longint'(got <= top), 1);
          check("R3", w, a, b, got >> w, longint'(a + b == top));
        end
      end
    end
  endtask

  initial begin
    longint got;
    longint ra, rb;
    // R1 idle state: zero operands
    directed("R1", 0, 0, 0);
    directed("R4", 256, 0, 256);
    directed("R4", 0, 256, 256);
    directed("R4", 256, 1, 0);
    directed("R4", 1, 256, 0);
    directed("R4", 256, 100, 99);
    directed("R5", 256, 256, 255);
    directed("R3", 128, 128, 256);
    directed("R3", 255, 1, 256);
    directed("R6", 255, 2, 0);
    directed("R6", 255, 255, 253);
    directed("R6", 200, 100, 43);
    sweep(8, "R1");
    sweep(2, "R7");
    sweep(5, "R7");
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      ra = (($urandom % 8) == 0) ? 64'sd65536 : longint'($urandom & 32'hFFFF);
      rb = (($urandom % 8) == 0) ? 64'sd65536 : longint'($urandom & 32'hFFFF);
      apply(16, ra, rb, got);
      check("R7", 16, ra, rb, got, ref_res(16, ra, rb));
    end
    apply(16, 65536, 65536, got);
    check("R5", 16, 65536, 65536, got, 65535);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule